// File: doc/BRIEF.md
# Automatic Page Response Generator

This block builds the response that goes back to a requesting endpoint when one of its page requests cannot be handed to software. A request is delivered together with a reason code. The block then returns a message that carries a 4-bit status, the requester's stream identifier, the request-group index and, in some cases, the request's process address space identifier (PASID).

For most reasons the result is fixed. In one case it is not: the request was dropped because the receive queue overflowed, the request carried a PASID, substreams are supported, and the global "always echo PASID" strap is clear. In that case the block asks an external stream-table walker about the stream. It waits for the answer and uses it to decide the status and whether the PASID is echoed.

The block handles one request at a time. Requests enter through a valid/ready handshake. The lookup uses a request/done handshake that returns an error flag and the per-stream "PASID required" bit. The response appears as a single-cycle pulse.

Top module: `autorsp_gen`

## Requirements
- R1: While reset is active and after it is released, `req_ready` is 1 and `rsp_valid` and `lk_valid` are 0 until a request is accepted.
- R2: The reason codes are 0 = queue overflow, 1 = queue disabled, 2 = queue abort error active, 3 = secure stream and 4 = record write abort. Any reason other than 0 gives status 4'b1111 (Response Failure) with no PASID and starts no lookup.
- R3: An overflow request with no PASID, or any overflow request while `cfg_substreams` is 0, gives status 4'b0000 (Success) with no PASID and starts no lookup.
- R4: An overflow request with a PASID, with `cfg_substreams` = 1 and `cfg_pasid_always` = 1, gives Success with the request's PASID echoed. No lookup is started, and the lookup inputs have no effect.
- R5: An overflow request with a PASID, with `cfg_substreams` = 1 and `cfg_pasid_always` = 0, raises `lk_valid` in the cycle after acceptance. `lk_valid` stays high with `lk_sid` equal to the request's stream ID and stable until `lk_done` is sampled high. No response is given before that.
- R6: When such a lookup completes with `lk_fail` = 0, the status is Success, and the PASID is echoed exactly when `lk_pasid_req` is 1.
- R7: When such a lookup completes with `lk_fail` = 1 (stream table disabled, stream ID out of range, fetch abort or illegal entry), the status is Response Failure with no PASID.
- R8: Every response copies the accepted request's stream ID and group index. The response holds them even if the request inputs change later. `rsp_pasid` is 0 whenever `rsp_has_pasid` is 0.
- R9: `rsp_valid` is a one-cycle pulse. It comes in the cycle after the accepting edge, or in the cycle after the edge that samples `lk_done`. `req_ready` is 0 from the cycle after acceptance until the cycle after the pulse.
- R10: A Response Failure status never carries a PASID.
- R11: A `lk_done` pulse while no lookup is pending has no effect on any output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request offered |
| req_ready | output | 1 | Block idle, request taken on this edge |
| req_cause | input | 3 | Reason the request was not queued |
| req_sid | input | SID_W | Stream ID of the request |
| req_prg | input | PRG_W | Request-group index |
| req_has_pasid | input | 1 | Request carried a PASID |
| req_pasid | input | PASID_W | PASID value of the request |
| cfg_substreams | input | 1 | Substreams supported strap |
| cfg_pasid_always | input | 1 | Always echo PASID on overflow strap |
| lk_valid | output | 1 | Stream-table lookup requested |
| lk_sid | output | SID_W | Stream ID to look up |
| lk_done | input | 1 | Lookup result present |
| lk_fail | input | 1 | Entry invalid or inaccessible |
| lk_pasid_req | input | 1 | Per-stream PASID-required bit |
| rsp_valid | output | 1 | Response pulse |
| rsp_code | output | 4 | Response status |
| rsp_sid | output | SID_W | Stream ID copied from the request |
| rsp_prg | output | PRG_W | Group index copied from the request |
| rsp_has_pasid | output | 1 | Response carries a PASID |
| rsp_pasid | output | PASID_W | PASID echoed, 0 when absent |

## Verification
The generator is tried with every non-overflow reason to confirm the fixed failure path. It is then tried with overflow requests both without a PASID and with substreams off, which separates the two no-lookup success paths. With the strap set, the bench drives contradicting lookup inputs, which shows they are ignored. The lookup path is run with error set and cleared, with the per-stream bit at both values, and with zero and several cycles of lookup delay. The request inputs are scrambled while the block is busy, and extreme stream and index values are used, so that fields taken live instead of latched are exposed. A stray lookup completion while idle completes the set.

// File: rtl/autorsp_pkg.sv
package autorsp_pkg;

  typedef enum logic [2:0] {
    CAUSE_OVERFLOW    = 3'd0,
    CAUSE_QUEUE_OFF   = 3'd1,
    CAUSE_ABORT_ERR   = 3'd2,
    CAUSE_SECURE      = 3'd3,
    CAUSE_WRITE_ABORT = 3'd4
  } cause_e;

  localparam logic [3:0] RC_SUCCESS = 4'b0000;
  localparam logic [3:0] RC_INVALID = 4'b0001;
  localparam logic [3:0] RC_FAILURE = 4'b1111;

  typedef enum logic [1:0] {
    ST_IDLE   = 2'd0,
    ST_LOOKUP = 2'd1,
    ST_EMIT   = 2'd2
  } state_e;

endpackage

// File: rtl/autorsp_rst_sync.sv
module autorsp_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic arst_n,
  output logic rst_n_o
);
  logic [STAGES-1:0] sync_q;

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) sync_q <= '0;
    else         sync_q <= {sync_q[STAGES-2:0], 1'b1};
  end

  assign rst_n_o = sync_q[STAGES-1];
endmodule

// File: rtl/autorsp_policy.sv
module autorsp_policy
  import autorsp_pkg::*;
(
  input  logic       cause_i,
  input  logic       has_pasid_i,
  input  logic       substreams_i,
  input  logic       pasid_always_i,
  input  logic       lk_fail_i,
  input  logic       lk_pasid_req_i,
  output logic       need_lookup_o,
  output logic [3:0] code_o,
  output logic       echo_o
);
  // cause_i is 1 when the reason is queue overflow
  logic pasid_path;

  assign pasid_path    = cause_i & has_pasid_i & substreams_i;
  assign need_lookup_o = pasid_path & ~pasid_always_i;

  always_comb begin
    code_o = RC_SUCCESS;
    echo_o = 1'b0;
    if (!cause_i) begin
      code_o = RC_FAILURE;
    end else if (!pasid_path) begin
      code_o = RC_SUCCESS;
    end else if (pasid_always_i) begin
      echo_o = 1'b1;
    end else if (lk_fail_i) begin
      code_o = RC_FAILURE;
    end else begin
      echo_o = lk_pasid_req_i;
    end
  end
endmodule

// File: rtl/autorsp_ctrl.sv
module autorsp_ctrl
  import autorsp_pkg::*;
#(
  parameter int SID_W   = 32,
  parameter int PRG_W   = 9,
  parameter int PASID_W = 20
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               req_valid,
  output logic               req_ready,
  input  logic [2:0]         req_cause,
  input  logic [SID_W-1:0]   req_sid,
  input  logic [PRG_W-1:0]   req_prg,
  input  logic               req_has_pasid,
  input  logic [PASID_W-1:0] req_pasid,
  output logic               sel_is_ovf,
  output logic               sel_has_pasid,
  input  logic               need_lookup,
  input  logic [3:0]         dec_code,
  input  logic               dec_echo,
  output logic               lk_valid,
  output logic [SID_W-1:0]   lk_sid,
  input  logic               lk_done,
  output logic               rsp_valid,
  output logic [3:0]         rsp_code,
  output logic [SID_W-1:0]   rsp_sid,
  output logic [PRG_W-1:0]   rsp_prg,
  output logic               rsp_has_pasid,
  output logic [PASID_W-1:0] rsp_pasid
);
  state_e st_q, st_d;

  logic [2:0]         cause_q;
  logic               hp_q;
  logic [SID_W-1:0]   sid_q;
  logic [PRG_W-1:0]   prg_q;
  logic [PASID_W-1:0] pasid_q;

  logic               idle, accept, load_rsp;
  logic [2:0]         sel_cause;
  logic [SID_W-1:0]   sel_sid;
  logic [PRG_W-1:0]   sel_prg;
  logic [PASID_W-1:0] sel_pasid;

  assign idle   = (st_q == ST_IDLE);
  assign accept = idle & req_valid;

  // live inputs while idle, latched copy afterwards
  assign sel_cause     = idle ? req_cause     : cause_q;
  assign sel_has_pasid = idle ? req_has_pasid : hp_q;
  assign sel_sid       = idle ? req_sid       : sid_q;
  assign sel_prg       = idle ? req_prg       : prg_q;
  assign sel_pasid     = idle ? req_pasid     : pasid_q;
  assign sel_is_ovf    = (sel_cause == CAUSE_OVERFLOW);

  assign load_rsp = (accept & ~need_lookup) | ((st_q == ST_LOOKUP) & lk_done);

  always_comb begin
    st_d = st_q;
    unique case (st_q)
      ST_IDLE:   if (req_valid) st_d = need_lookup ? ST_LOOKUP : ST_EMIT;
      ST_LOOKUP: if (lk_done)   st_d = ST_EMIT;
      ST_EMIT:                  st_d = ST_IDLE;
      default:                  st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) st_q <= ST_IDLE;
    else        st_q <= st_d;
  end

  always_ff @(posedge clk) begin
    if (accept) begin
      cause_q <= req_cause;
      hp_q    <= req_has_pasid;
      sid_q   <= req_sid;
      prg_q   <= req_prg;
      pasid_q <= req_pasid;
    end
  end

  always_ff @(posedge clk) begin
    if (load_rsp) begin
      rsp_code      <= dec_code;
      rsp_sid       <= sel_sid;
      rsp_prg       <= sel_prg;
      rsp_has_pasid <= dec_echo;
      rsp_pasid     <= dec_echo ? sel_pasid : '0;
    end
  end

  assign req_ready = idle;
  assign lk_valid  = (st_q == ST_LOOKUP);
  assign lk_sid    = sid_q;
  assign rsp_valid = (st_q == ST_EMIT);
endmodule

// File: rtl/autorsp_gen.sv
module autorsp_gen #(
  parameter int SID_W   = 32,
  parameter int PRG_W   = 9,
  parameter int PASID_W = 20
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               req_valid,
  output logic               req_ready,
  input  logic [2:0]         req_cause,
  input  logic [SID_W-1:0]   req_sid,
  input  logic [PRG_W-1:0]   req_prg,
  input  logic               req_has_pasid,
  input  logic [PASID_W-1:0] req_pasid,
  input  logic               cfg_substreams,
  input  logic               cfg_pasid_always,
  output logic               lk_valid,
  output logic [SID_W-1:0]   lk_sid,
  input  logic               lk_done,
  input  logic               lk_fail,
  input  logic               lk_pasid_req,
  output logic               rsp_valid,
  output logic [3:0]         rsp_code,
  output logic [SID_W-1:0]   rsp_sid,
  output logic [PRG_W-1:0]   rsp_prg,
  output logic               rsp_has_pasid,
  output logic [PASID_W-1:0] rsp_pasid
);
  logic       rst_sync_n;
  logic       sel_is_ovf, sel_has_pasid, need_lookup, dec_echo;
  logic [3:0] dec_code;

  autorsp_rst_sync #(.STAGES(2)) i_rst_sync (
    .clk     (clk),
    .arst_n  (rst_n),
    .rst_n_o (rst_sync_n)
  );

  autorsp_policy i_policy (
    .cause_i        (sel_is_ovf),
    .has_pasid_i    (sel_has_pasid),
    .substreams_i   (cfg_substreams),
    .pasid_always_i (cfg_pasid_always),
    .lk_fail_i      (lk_fail),
    .lk_pasid_req_i (lk_pasid_req),
    .need_lookup_o  (need_lookup),
    .code_o         (dec_code),
    .echo_o         (dec_echo)
  );

  autorsp_ctrl #(.SID_W(SID_W), .PRG_W(PRG_W), .PASID_W(PASID_W)) i_ctrl (
    .clk           (clk),
    .rst_n         (rst_sync_n),
    .req_valid     (req_valid),
    .req_ready     (req_ready),
    .req_cause     (req_cause),
    .req_sid       (req_sid),
    .req_prg       (req_prg),
    .req_has_pasid (req_has_pasid),
    .req_pasid     (req_pasid),
    .sel_is_ovf    (sel_is_ovf),
    .sel_has_pasid (sel_has_pasid),
    .need_lookup   (need_lookup),
    .dec_code      (dec_code),
    .dec_echo      (dec_echo),
    .lk_valid      (lk_valid),
    .lk_sid        (lk_sid),
    .lk_done       (lk_done),
    .rsp_valid     (rsp_valid),
    .rsp_code      (rsp_code),
    .rsp_sid       (rsp_sid),
    .rsp_prg       (rsp_prg),
    .rsp_has_pasid (rsp_has_pasid),
    .rsp_pasid     (rsp_pasid)
  );
endmodule

// File: rtl/autorsp_chk.sv
module autorsp_chk #(
  parameter int SID_W   = 32,
  parameter int PASID_W = 20
) (
  input logic               clk,
  input logic               rst_n,
  input logic               req_valid,
  input logic               req_ready,
  input logic [2:0]         req_cause,
  input logic               cfg_substreams,
  input logic               lk_valid,
  input logic [SID_W-1:0]   lk_sid,
  input logic               lk_done,
  input logic               rsp_valid,
  input logic [3:0]         rsp_code,
  input logic               rsp_has_pasid,
  input logic [PASID_W-1:0] rsp_pasid
);
  // R10
  fail_no_pasid_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid && rsp_code == 4'b1111 |-> !rsp_has_pasid);

  // R3
  nosub_no_pasid_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid && !cfg_substreams |-> !rsp_has_pasid);

  // R8
  pasid_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid && !rsp_has_pasid |-> rsp_pasid == '0);

  // R5
  lk_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    lk_valid && !lk_done |=> lk_valid && $stable(lk_sid));

  // R5
  lk_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    lk_valid |-> !req_ready && !rsp_valid);

  // R9
  one_at_a_time_chk: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && req_ready |=> !req_ready);

  // R9
  rsp_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |=> !rsp_valid && req_ready);

  // R2
  cause_fail_chk: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && req_ready && req_cause != 3'd0 |=> rsp_valid && rsp_code == 4'b1111);
endmodule

bind autorsp_gen autorsp_chk #(.SID_W(SID_W), .PASID_W(PASID_W)) i_chk (
  .clk            (clk),
  .rst_n          (rst_n),
  .req_valid      (req_valid),
  .req_ready      (req_ready),
  .req_cause      (req_cause),
  .cfg_substreams (cfg_substreams),
  .lk_valid       (lk_valid),
  .lk_sid         (lk_sid),
  .lk_done        (lk_done),
  .rsp_valid      (rsp_valid),
  .rsp_code       (rsp_code),
  .rsp_has_pasid  (rsp_has_pasid),
  .rsp_pasid      (rsp_pasid)
);

// File: tb/test_autorsp_gen.sv
`timescale 1ns/1ps
module test_autorsp_gen;
  localparam int SID_W = 32, PRG_W = 9, PASID_W = 20;

  logic               clk = 1'b0;
  logic               rst_n;
  logic               req_valid, req_ready;
  logic [2:0]         req_cause;
  logic [SID_W-1:0]   req_sid;
  logic [PRG_W-1:0]   req_prg;
  logic               req_has_pasid;
  logic [PASID_W-1:0] req_pasid;
  logic               cfg_substreams, cfg_pasid_always;
  logic               lk_valid;
  logic [SID_W-1:0]   lk_sid;
  logic               lk_done, lk_fail, lk_pasid_req;
  logic               rsp_valid;
  logic [3:0]         rsp_code;
  logic [SID_W-1:0]   rsp_sid;
  logic [PRG_W-1:0]   rsp_prg;
  logic               rsp_has_pasid;
  logic [PASID_W-1:0] rsp_pasid;

  int  n_tests = 0;
  int  n_fail  = 0;
  bit  finished = 0;

  always #2.5 clk = ~clk;

  autorsp_gen #(.SID_W(SID_W), .PRG_W(PRG_W), .PASID_W(PASID_W)) i_autorsp_gen (.*);

  task automatic check(input bit ok, input string rq, input logic [63:0] act, input logic [63:0] exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", rq, act, exp);
    end
  endtask

  // one request through the block, with the expected result worked out from the requirements
  task automatic run(input logic [2:0] cause, input logic [31:0] sid, input logic [8:0] prg,
                     input bit hp, input logic [19:0] pasid, input bit lkf, input bit lkp,
                     input int dly, input string rq);
    bit         exp_lk, exp_echo;
    logic [3:0] exp_code;
    exp_lk = (cause == 3'd0) && hp && cfg_substreams && !cfg_pasid_always;
    exp_echo = 1'b0;
    if (cause != 3'd0)                exp_code = 4'b1111;
    else if (!hp || !cfg_substreams)  exp_code = 4'b0000;
    else if (cfg_pasid_always) begin  exp_code = 4'b0000; exp_echo = 1'b1; end
    else if (lkf)                     exp_code = 4'b1111;
    else begin                        exp_code = 4'b0000; exp_echo = lkp; end

    lk_fail = lkf; lk_pasid_req = lkp;
    req_valid = 1'b1; req_cause = cause; req_sid = sid; req_prg = prg;
    req_has_pasid = hp; req_pasid = pasid;
    check(req_ready == 1'b1, {rq, " R9 ready idle"}, req_ready, 1);
    @(posedge clk); @(negedge clk);
    req_valid = 1'b0; req_sid = ~sid; req_prg = ~prg; req_pasid = ~pasid;
    req_has_pasid = ~hp; req_cause = 3'd1;
    if (exp_lk) begin
      check(lk_valid == 1'b1, {rq, " R5 lk_valid"}, lk_valid, 1);
      check(lk_sid == sid, {rq, " R5 lk_sid"}, lk_sid, sid);
      check(rsp_valid == 1'b0, {rq, " R5 no early rsp"}, rsp_valid, 0);
      for (int k = 0; k < dly; k++) begin
        @(negedge clk);
        check(lk_valid && !rsp_valid && !req_ready && lk_sid == sid, {rq, " R5 lookup hold"},
              {lk_valid, rsp_valid, req_ready}, 3'b100);
      end
      lk_done = 1'b1;
      @(posedge clk); @(negedge clk);
      lk_done = 1'b0;
    end else begin
      check(lk_valid == 1'b0, {rq, " no lookup"}, lk_valid, 0);
    end
    check(rsp_valid == 1'b1, {rq, " R9 rsp pulse"}, rsp_valid, 1);
    check(rsp_code == exp_code, {rq, " code"}, rsp_code, exp_code);
    check(rsp_has_pasid == exp_echo, {rq, " pasid flag"}, rsp_has_pasid, exp_echo);
    check(rsp_pasid == (exp_echo ? pasid : 20'd0), {rq, " R8 pasid value"}, rsp_pasid,
          exp_echo ? pasid : 20'd0);
    check(rsp_sid == sid, {rq, " R8 sid"}, rsp_sid, sid);
    check(rsp_prg == prg, {rq, " R8 prg"}, rsp_prg, prg);
    @(negedge clk);
    check(rsp_valid == 1'b0 && req_ready == 1'b1, {rq, " R9 pulse end"},
          {rsp_valid, req_ready}, 2'b01);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      n_tests++; n_fail++;
      $display("FAIL watchdog expired actual=0 expected=1");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; req_valid = 1'b0; req_cause = '0; req_sid = '0; req_prg = '0;
    req_has_pasid = 1'b0; req_pasid = '0; cfg_substreams = 1'b1; cfg_pasid_always = 1'b0;
    lk_done = 1'b0; lk_fail = 1'b0; lk_pasid_req = 1'b0;
    repeat (3) @(negedge clk);
    check(req_ready && !rsp_valid && !lk_valid, "R1 in reset", {req_ready, rsp_valid, lk_valid}, 3'b100);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    check(req_ready && !rsp_valid && !lk_valid, "R1 after reset", {req_ready, rsp_valid, lk_valid}, 3'b100);

    // R2 every non-overflow reason
    for (int c = 1; c <= 4; c++)
      run(3'(c), 32'h1000 + 32'(c), 9'(c * 7), 1'b1, 20'hABCDE, 1'b0, 1'b1, 0, "R2 cause");
    run(3'd6, 32'h77, 9'h3, 1'b1, 20'h11111, 1'b0, 1'b1, 0, "R2 other cause");

    // R3
    run(3'd0, 32'h2222, 9'h10, 1'b0, 20'h55555, 1'b1, 1'b1, 0, "R3 ovf no pasid");
    cfg_substreams = 1'b0;
    run(3'd0, 32'h2223, 9'h11, 1'b1, 20'h55555, 1'b1, 1'b1, 0, "R3 no substreams");
    cfg_substreams = 1'b1;

    // R4 lookup inputs contradict and must be ignored
    cfg_pasid_always = 1'b1;
    run(3'd0, 32'h3333, 9'h1F, 1'b1, 20'h12345, 1'b1, 1'b0, 0, "R4 strap echo");
    cfg_pasid_always = 1'b0;

    // R5 R6 R7 R8
    run(3'd0, 32'h4444, 9'h20, 1'b1, 20'h9ABCD, 1'b0, 1'b1, 0, "R6 ppar1 dly0");
    run(3'd0, 32'h4445, 9'h21, 1'b1, 20'h9ABCD, 1'b0, 1'b0, 3, "R6 ppar0 dly3");
    run(3'd0, 32'h4446, 9'h22, 1'b1, 20'hFEDCB, 1'b1, 1'b1, 2, "R7 lookup fail");
    run(3'd0, 32'hFFFFFFFF, 9'h1FF, 1'b1, 20'hFFFFF, 1'b0, 1'b1, 5, "R8 extremes");
    run(3'd2, 32'h0, 9'h0, 1'b0, 20'h0, 1'b0, 1'b0, 0, "R8 zeros");

    // R11 stray completion while idle
    lk_done = 1'b1; lk_fail = 1'b0; lk_pasid_req = 1'b1;
    @(negedge clk);
    lk_done = 1'b0;
    check(!rsp_valid && !lk_valid && req_ready, "R11 stray done", {rsp_valid, lk_valid, req_ready}, 3'b001);
    @(negedge clk);
    check(!rsp_valid && req_ready, "R11 stray done later", {rsp_valid, req_ready}, 2'b01);

    // mixed patterns
    for (int i = 0; i < 24; i++) begin
      cfg_substreams   = (i % 5) != 4;
      cfg_pasid_always = (i % 7) == 3;
      run(3'(i % 6 == 5 ? 3 : (i % 3 == 0 ? 1 : 0)), 32'(i * 32'h01010101), 9'(i * 21),
          1'(i % 4 != 1), 20'(i * 20'h0B3C7), 1'(i % 3 == 2), 1'(i % 2), i % 4, "R6 R7 mix");
    end

    finished = 1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule